// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block is the address arithmetic of a digital signal processor's data path. It holds a bank of address registers and a block-size register. Each request names one register and a modification mode. The block returns the operand address for that access and writes the modified value back into the register, so that the next access in a loop finds its pointer already advanced.

Register 0 also serves as the shared index step for the indexed modes. The block-size register sets the length of a circular buffer. The buffer starts at the register value with its low bits cleared, down to the smallest power of two that is not below the length. A reverse-carry mode advances a pointer through the scrambled order used by radix-2 FFT stages. A load port presets any register. Results are registered and appear one clock after the request.

Top module: `addr_gen_unit`

## Requirements
- R1: After synchronous reset, all eight address registers and the block-size register hold 0, and out_valid, eff_addr and upd_value are 0.
- R2: With ld_en high, ld_target codes 0 to 7 write ld_data into that address register and code 8 writes it into the block-size register. If a load and a request name the same register in the same cycle, the register ends up holding ld_data.
- R3: Mode code 0 (keep) returns the register value as eff_addr and leaves the register unchanged.
- R4: Mode codes 1 and 2 return the register value as eff_addr and then add or subtract one, modulo 2^16.
- R5: Mode code 3 returns the register value and then adds register 0 to it, modulo 2^16.
- R6: Mode code 4 returns the register value and then adds register 0 with the carry running from bit 15 toward bit 0. With register 0 at 8 and a start of 0, this produces the sequence 0, 8, 4, 12, 2, 10, 6, 14.
- R7: Mode code 5 returns the register plus req_offset, read as a signed 16-bit value, as eff_addr, and leaves the register unchanged.
- R8: Mode codes 6 (circular step of one) and 7 (circular step of register 0) return the register value. The low bits then move within a buffer of block-size entries: a result that reaches or passes the length is reduced by the length, and the base bits above the power-of-two span are kept.
- R9: In mode 7, a signed negative register 0 that takes the buffer index below zero wraps it forward by the length.
- R10: When the block-size register is 0, modes 6 and 7 act as plain linear additions of 1 and of register 0.
- R11: out_valid, eff_addr and upd_value update on the clock edge that follows a request, with upd_value the value written back. A request in the very next cycle already sees the updated register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_sel | input | 3 | Address register used by the request |
| req_mode | input | 3 | Modification mode code |
| req_offset | input | 16 | Signed constant for the offset mode |
| ld_en | input | 1 | Load strobe |
| ld_target | input | 4 | Load destination: 0-7 address register, 8 block size |
| ld_data | input | 16 | Load value |
| out_valid | output | 1 | Registered result valid |
| eff_addr | output | 16 | Operand address of the request |
| upd_value | output | 16 | New value of the selected register |

## Verification
The circular properties assume that a pointer lies inside its buffer before a circular request, that is, its low index is below the block size, and that the magnitude of the step does not exceed the block size. Only then is a single correction by the length enough. The stimulus loads pointers inside their buffers and uses steps of 1, 3 and -2 against lengths of 5 and 8. Pointers are loaded only through the load port, and any change of the block size comes before the requests that depend on it.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_KEEP = 3'd0,
    AM_INC  = 3'd1,
    AM_DEC  = 3'd2,
    AM_IDX  = 3'd3,
    AM_REV  = 3'd4,
    AM_OFS  = 3'd5,
    AM_CINC = 3'd6,
    AM_CIDX = 3'd7
  } agu_mode_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [SELW:0]   ld_target,
  input  logic [AW-1:0]   ld_data,
  input  logic            upd_en,
  input  logic [SELW-1:0] upd_sel,
  input  logic [AW-1:0]   upd_data,
  input  logic [SELW-1:0] rd_sel,
  output logic [AW-1:0]   rd_data,
  output logic [AW-1:0]   idx_data,
  output logic [AW-1:0]   bk_data
);
  localparam logic [SELW:0] BK_CODE = (SELW+1)'(NREG);

  logic [AW-1:0] ar_q [NREG];
  logic [AW-1:0] bk_q;

  // Each register has its own write logic; the load port wins on a clash.
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_ar
      always_ff @(posedge clk) begin
        if (rst)
          ar_q[i] <= '0;
        else if (ld_en && ld_target == (SELW+1)'(i))
          ar_q[i] <= ld_data;
        else if (upd_en && upd_sel == SELW'(i))
          ar_q[i] <= upd_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      bk_q <= '0;
    else if (ld_en && ld_target == BK_CODE)
      bk_q <= ld_data;
  end

  assign rd_data  = ar_q[rd_sel];
  assign idx_data = ar_q[0];
  assign bk_data  = bk_q;
endmodule

// File: rtl/agu_revadd.sv
module agu_revadd #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] a_rev, b_rev, s_rev;

  // Mirror the operands, add normally, mirror back: the carry runs downward.
  generate
    for (genvar i = 0; i < AW; i++) begin : g_mirror
      assign a_rev[i] = a[AW-1-i];
      assign b_rev[i] = b[AW-1-i];
      assign sum[i]   = s_rev[AW-1-i];
    end
  endgenerate

  assign s_rev = a_rev + b_rev;
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] blen,
  output logic [AW-1:0] nxt
);
  localparam int SW = AW + 2;

  // All-ones mask covering the smallest power of two not below len.
  function automatic logic [AW-1:0] span_mask(input logic [AW-1:0] len);
    logic [AW-1:0] m;
    m = len - 1'b1;
    for (int k = 0; k < AW; k++)
      m = m | (m >> 1);
    return m;
  endfunction

  logic [AW-1:0]        mask, idx;
  logic signed [SW-1:0] raw, wrapped, len_s, step_s;

  assign mask   = span_mask(blen);
  assign idx    = cur & mask;
  assign len_s  = $signed({2'b00, blen});
  assign step_s = $signed({{2{step[AW-1]}}, step});
  assign raw    = $signed({2'b00, idx}) + step_s;

  always_comb begin
    if (raw < 0)
      wrapped = raw + len_s;
    else if (raw >= len_s)
      wrapped = raw - len_s;
    else
      wrapped = raw;
  end

  always_comb begin
    if (blen == '0)
      nxt = cur + step;
    else
      nxt = (cur & ~mask) | (wrapped[AW-1:0] & mask);
  end
endmodule

// File: rtl/agu_modify.sv
module agu_modify
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] blen,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] eff,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ONE = AW'(1);

  agu_mode_e     mode_e;
  logic [AW-1:0] rev_sum, circ_nxt, circ_step;

  assign mode_e    = agu_mode_e'(mode);
  assign circ_step = (mode_e == AM_CIDX) ? idx : ONE;

  agu_revadd #(.AW(AW)) i_revadd (
    .a   (cur),
    .b   (idx),
    .sum (rev_sum)
  );

  agu_circ #(.AW(AW)) i_circ (
    .cur  (cur),
    .step (circ_step),
    .blen (blen),
    .nxt  (circ_nxt)
  );

  always_comb begin
    eff = cur;
    nxt = cur;
    unique case (mode_e)
      AM_KEEP: nxt = cur;
      AM_INC:  nxt = cur + ONE;
      AM_DEC:  nxt = cur - ONE;
      AM_IDX:  nxt = cur + idx;
      AM_REV:  nxt = rev_sum;
      AM_OFS:  eff = cur + offset;
      AM_CINC,
      AM_CIDX: nxt = circ_nxt;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [SELW-1:0] req_sel,
  input  logic [2:0]      req_mode,
  input  logic [AW-1:0]   req_offset,
  input  logic            ld_en,
  input  logic [SELW:0]   ld_target,
  input  logic [AW-1:0]   ld_data,
  output logic            out_valid,
  output logic [AW-1:0]   eff_addr,
  output logic [AW-1:0]   upd_value
);
  logic [AW-1:0] cur_q, idx_q, bk_q;
  logic [AW-1:0] eff_c, nxt_c;

  agu_regfile #(.AW(AW), .NREG(NREG)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_en),
    .ld_target (ld_target),
    .ld_data   (ld_data),
    .upd_en    (req_valid),
    .upd_sel   (req_sel),
    .upd_data  (nxt_c),
    .rd_sel    (req_sel),
    .rd_data   (cur_q),
    .idx_data  (idx_q),
    .bk_data   (bk_q)
  );

  agu_modify #(.AW(AW)) i_modify (
    .mode   (req_mode),
    .cur    (cur_q),
    .idx    (idx_q),
    .blen   (bk_q),
    .offset (req_offset),
    .eff    (eff_c),
    .nxt    (nxt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      eff_addr  <= '0;
      upd_value <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        eff_addr  <= eff_c;
        upd_value <= nxt_c;
      end
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [2:0]    req_mode,
  input logic [AW-1:0] req_offset,
  input logic          out_valid,
  input logic [AW-1:0] eff_addr,
  input logic [AW-1:0] upd_value,
  input logic [AW-1:0] idx_q,
  input logic [AW-1:0] bk_q
);
  function automatic logic [AW-1:0] pow2_mask(input logic [AW-1:0] len);
    logic [AW:0] p;
    p = 1;
    while (p < {1'b0, len}) p = p << 1;
    return p[AW-1:0] - 1'b1;
  endfunction

  logic circ_req;
  assign circ_req = req_valid && (req_mode == AM_CINC || req_mode == AM_CIDX);

  p_valid_track_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  p_keep_same_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_KEEP) |=> upd_value == eff_addr);
  p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_INC) |=> upd_value == eff_addr + AW'(1));
  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_DEC) |=> upd_value == eff_addr - AW'(1));
  p_index_add_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_IDX) |=> upd_value == eff_addr + $past(idx_q));
  p_offset_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_OFS) |=> eff_addr == upd_value + $past(req_offset));
  p_circ_base_r8: assert property (@(posedge clk) disable iff (rst)
    (circ_req && bk_q != '0) |=>
      (upd_value & ~pow2_mask($past(bk_q))) == (eff_addr & ~pow2_mask($past(bk_q))));
  p_circ_inside_r8: assert property (@(posedge clk) disable iff (rst)
    (circ_req && bk_q != '0) |=> (upd_value & pow2_mask($past(bk_q))) < $past(bk_q));
  p_linear_bk0_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_CINC && bk_q == '0) |=> upd_value == eff_addr + AW'(1));
endmodule

bind addr_gen_unit agu_checker #(.AW(AW)) i_agu_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .req_offset (req_offset),
  .out_valid  (out_valid),
  .eff_addr   (eff_addr),
  .upd_value  (upd_value),
  .idx_q      (idx_q),
  .bk_q       (bk_q)
);

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_sel;
  logic [2:0]  req_mode;
  logic [15:0] req_offset;
  logic        ld_en;
  logic [3:0]  ld_target;
  logic [15:0] ld_data;
  logic        out_valid;
  logic [15:0] eff_addr;
  logic [15:0] upd_value;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
    .req_mode(req_mode), .req_offset(req_offset), .ld_en(ld_en),
    .ld_target(ld_target), .ld_data(ld_data), .out_valid(out_valid),
    .eff_addr(eff_addr), .upd_value(upd_value)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] tgt, input logic [15:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_target = tgt; ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // One request; outputs sampled at the next falling edge.
  task automatic access(input logic [2:0] sel, input logic [2:0] mode,
                        input logic [15:0] ofs, input string tag,
                        input logic [15:0] exp_eff, input logic [15:0] exp_upd);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_mode = mode; req_offset = ofs;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {15'd0, out_valid}, 16'd1);
    chk({tag, " eff"}, eff_addr, exp_eff);
    chk({tag, " upd"}, upd_value, exp_upd);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 valid", {15'd0, out_valid}, 16'd0);
    chk("R1 eff", eff_addr, 16'h0000);
    chk("R1 upd", upd_value, 16'h0000);
    access(3'd7, 3'd0, 16'h0, "R1 ar7", 16'h0000, 16'h0000);
    access(3'd2, 3'd6, 16'h0, "R1 bk zero", 16'h0000, 16'h0001);
  endtask

  task automatic t_load_keep;
    load(4'd6, 16'hBEEF);
    access(3'd6, 3'd0, 16'h0, "R2 R3 keep", 16'hBEEF, 16'hBEEF);
    access(3'd6, 3'd0, 16'h0, "R3 unchanged", 16'hBEEF, 16'hBEEF);
    // Load and increment of the same register in one cycle.
    @(negedge clk);
    ld_en = 1'b1; ld_target = 4'd6; ld_data = 16'h1234;
    req_valid = 1'b1; req_sel = 3'd6; req_mode = 3'd1; req_offset = 16'h0;
    @(negedge clk);
    ld_en = 1'b0; req_valid = 1'b0;
    chk("R2 clash eff", eff_addr, 16'hBEEF);
    access(3'd6, 3'd0, 16'h0, "R2 load wins", 16'h1234, 16'h1234);
  endtask

  task automatic t_incdec;
    load(4'd2, 16'hFFFF);
    access(3'd2, 3'd1, 16'h0, "R4 inc wrap", 16'hFFFF, 16'h0000);
    access(3'd2, 3'd2, 16'h0, "R4 dec wrap", 16'h0000, 16'hFFFF);
    access(3'd2, 3'd2, 16'h0, "R4 dec", 16'hFFFF, 16'hFFFE);
  endtask

  task automatic t_index;
    load(4'd0, 16'h0010);
    load(4'd4, 16'h1000);
    access(3'd4, 3'd3, 16'h0, "R5 idx 1", 16'h1000, 16'h1010);
    access(3'd4, 3'd3, 16'h0, "R5 idx 2", 16'h1010, 16'h1020);
  endtask

  task automatic t_bitrev;
    logic [15:0] seq [8] = '{16'd0, 16'd8, 16'd4, 16'd12, 16'd2, 16'd10, 16'd6, 16'd14};
    load(4'd0, 16'h0008);
    load(4'd3, 16'h0000);
    for (int i = 0; i < 7; i++)
      access(3'd3, 3'd4, 16'h0, "R6 rev", seq[i], seq[i+1]);
    access(3'd3, 3'd4, 16'h0, "R6 rev end", 16'd14, 16'd1);
  endtask

  task automatic t_offset;
    load(4'd5, 16'h0200);
    access(3'd5, 3'd5, 16'h0005, "R7 plus", 16'h0205, 16'h0200);
    access(3'd5, 3'd5, 16'hFFFD, "R7 minus", 16'h01FD, 16'h0200);
  endtask

  task automatic t_circ;
    load(4'd8, 16'd5);
    load(4'd1, 16'h0103);
    access(3'd1, 3'd6, 16'h0, "R8 step", 16'h0103, 16'h0104);
    access(3'd1, 3'd6, 16'h0, "R8 wrap", 16'h0104, 16'h0100);
    load(4'd0, 16'd3);
    access(3'd1, 3'd7, 16'h0, "R8 idx", 16'h0100, 16'h0103);
    access(3'd1, 3'd7, 16'h0, "R8 idx wrap", 16'h0103, 16'h0101);
    load(4'd0, 16'hFFFE);
    access(3'd1, 3'd7, 16'h0, "R9 under", 16'h0101, 16'h0104);
    load(4'd8, 16'd8);
    load(4'd1, 16'h0207);
    access(3'd1, 3'd6, 16'h0, "R8 pow2", 16'h0207, 16'h0200);
  endtask

  task automatic t_bk_zero;
    load(4'd8, 16'd0);
    load(4'd1, 16'h0104);
    access(3'd1, 3'd6, 16'h0, "R10 lin inc", 16'h0104, 16'h0105);
    access(3'd1, 3'd7, 16'h0, "R10 lin idx", 16'h0105, 16'h0103);
  endtask

  task automatic t_back_to_back;
    load(4'd5, 16'h0040);
    @(negedge clk);
    req_valid = 1'b1; req_sel = 3'd5; req_mode = 3'd1; req_offset = 16'h0;
    @(negedge clk);
    chk("R11 first eff", eff_addr, 16'h0040);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 second eff", eff_addr, 16'h0041);
    chk("R11 second upd", upd_value, 16'h0042);
    @(negedge clk);
    chk("R11 idle", {15'd0, out_valid}, 16'd0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_sel = '0; req_mode = '0; req_offset = '0;
    ld_en = 1'b0; ld_target = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_keep();
    t_incdec();
    t_index();
    t_bitrev();
    t_offset();
    t_circ();
    t_bk_zero();
    t_back_to_back();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule